// File: doc/BRIEF.md
# Load-Use Stall Scoreboard

This block is the timing unit of an in-order pipeline model. Each cycle it may accept one instruction descriptor. The descriptor holds a base cycle count, up to two source register references, an optional load destination, and control-transfer information. The block reports, one cycle later, how many cycles that instruction costs. The cost is the base count plus any penalty from reading a register loaded by the instruction just before it, plus a bubble for a taken control transfer that has no delay slot.

A one-bit-per-register scoreboard covers the sixteen general registers. A load marks its destination only for the instruction that follows it. Beside the per-instruction result, five saturating counters keep running totals: all cycles, load-use stall cycles, control-transfer bubbles, taken transfers and untaken transfers. Multi-register transfer instructions are charged only their base count.

Top module: `ldstall_sb`

## Requirements
- R1: While reset is high and after it, `res_vld` is 0, all five counters read 0 and no register is marked as loaded.
- R2: A load's destination is marked only for the next accepted instruction. A load whose own source names its own destination does not stall on that mark.
- R3: Each present source whose register was loaded by the previous accepted instruction adds one cycle and adds one to `cnt_ld_stall`. Two such sources add two.
- R4: A source whose valid flag is 0 never adds a stall, whatever its index.
- R5: The marks reflect only the immediately preceding accepted instruction. An accepted instruction without a load clears every mark.
- R6: A control transfer (`is_cti`=1) with `cti_taken`=1 and `has_slot`=0 adds one cycle and increments `cnt_cti_stall`. With `has_slot`=1 it adds nothing.
- R7: Every accepted control transfer increments `cnt_taken` when `cti_taken`=1 and `cnt_untaken` when it is 0. `cti_taken` and `has_slot` have no effect when `is_cti`=0.
- R8: One cycle after an accepted instruction, `res_vld` is 1 and `res_cyc` equals base plus all stall cycles. The same value is added to `cnt_cycles`.
- R9: An instruction with `multi_xfer`=1 reports exactly its base count. It touches no counter other than `cnt_cycles`, never stalls, and leaves no mark, even if `ld_vld` is set.
- R10: Every counter stops at its all-ones value instead of wrapping.
- R11: A cycle with `ins_vld`=0 produces `res_vld`=0 and changes neither the marks nor any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_vld | input | 1 | Instruction descriptor present this cycle |
| ins_base | input | CYC_W | Base cycle count of the instruction |
| src_a_vld | input | 1 | First source register present |
| src_a_idx | input | 4 | First source register index |
| src_b_vld | input | 1 | Second source register present |
| src_b_idx | input | 4 | Second source register index |
| ld_vld | input | 1 | Instruction is a load with a destination |
| ld_idx | input | 4 | Load destination register index |
| is_cti | input | 1 | Instruction is a control transfer |
| cti_taken | input | 1 | Control transfer is taken |
| has_slot | input | 1 | Control transfer has a delay slot |
| multi_xfer | input | 1 | Multi-register load/store instruction |
| res_vld | output | 1 | Result for the previous cycle's instruction |
| res_cyc | output | CYC_W+2 | Total cycles of that instruction |
| cnt_cycles | output | CNT_W | Saturating sum of all reported cycles |
| cnt_ld_stall | output | CNT_W | Saturating count of load-use stall cycles |
| cnt_cti_stall | output | CNT_W | Saturating count of control-transfer bubbles |
| cnt_taken | output | CNT_W | Saturating count of taken transfers |
| cnt_untaken | output | CNT_W | Saturating count of untaken transfers |

## Verification
The properties assume that descriptor fields are meaningful only when `ins_vld` is high. They also assume that those fields and the reset are driven to known values from the first clock edge. The bounds on `res_cyc` assume that the base count plus three fits its width, which `CYC_W+2` guarantees. The stimulus changes inputs only on the falling edge. It holds every field at a defined value even on idle cycles, and it drives `cti_taken` and `has_slot` with `is_cti` low as well, to show those two flags are then ignored.

// File: rtl/ldstall_pkg.sv
package ldstall_pkg;

    localparam int NREGS  = 16;
    localparam int RIDX_W = $clog2(NREGS);

    typedef logic [NREGS-1:0] regmask_t;

    typedef struct packed {
        logic              vld;
        logic [RIDX_W-1:0] idx;
    } regref_t;

    typedef enum logic [1:0] {
        CTI_NONE,
        CTI_UNTAKEN,
        CTI_TAKEN_SLOT,
        CTI_TAKEN_BUBBLE
    } cti_kind_e;

    typedef struct packed {
        logic [1:0] ld;
        logic       bubble;
        logic       taken;
        logic       untaken;
    } charge_t;

    function automatic logic ref_hits(regmask_t m, regref_t r);
        return r.vld && m[r.idx];
    endfunction

    function automatic regmask_t dest_bit(regref_t r);
        regmask_t m;
        m = '0;
        if (r.vld) m[r.idx] = 1'b1;
        return m;
    endfunction

    function automatic cti_kind_e classify(logic xfer, logic tk, logic slot);
        if (!xfer)     return CTI_NONE;
        else if (!tk)  return CTI_UNTAKEN;
        else if (slot) return CTI_TAKEN_SLOT;
        else           return CTI_TAKEN_BUBBLE;
    endfunction

endpackage

// File: rtl/ldstall_board.sv
module ldstall_board
    import ldstall_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    adv,
    input  logic    blk,
    input  regref_t src_a,
    input  regref_t src_b,
    input  regref_t dest,
    output logic [1:0] hit_cnt
);

    regmask_t committed;
    regmask_t pending;

    // pending is rebuilt from scratch for every instruction
    always_comb begin
        pending = blk ? '0 : dest_bit(dest);
    end

    always_comb begin
        hit_cnt = {1'b0, ref_hits(committed, src_a)} + {1'b0, ref_hits(committed, src_b)};
    end

    always_ff @(posedge clk) begin
        if (rst)
            committed <= '0;
        else if (adv)
            committed <= pending;
    end

endmodule

// File: rtl/ldstall_calc.sv
module ldstall_calc
    import ldstall_pkg::*;
#(
    parameter int CYC_W = 8
) (
    input  logic [CYC_W-1:0] base,
    input  logic [1:0]       hits,
    input  cti_kind_e        kind,
    input  logic             blk,
    output logic [CYC_W+1:0] cyc,
    output charge_t          chg
);

    localparam int RES_W = CYC_W + 2;

    always_comb begin
        chg = '0;
        if (!blk) begin
            chg.ld = hits;
            unique case (kind)
                CTI_UNTAKEN:      chg.untaken = 1'b1;
                CTI_TAKEN_SLOT:   chg.taken   = 1'b1;
                CTI_TAKEN_BUBBLE: begin
                    chg.taken  = 1'b1;
                    chg.bubble = 1'b1;
                end
                default: ;
            endcase
        end
        cyc = {2'b00, base} + RES_W'(chg.ld) + RES_W'(chg.bubble);
    end

endmodule

// File: rtl/ldstall_satcnt.sv
module ldstall_satcnt #(
    parameter int CNT_W = 32,
    parameter int INC_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W:0] sum;

    always_comb begin
        sum = {1'b0, cnt} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (en)
            cnt <= sum[CNT_W] ? TOP : sum[CNT_W-1:0];
    end

endmodule

// File: rtl/ldstall_sb.sv
module ldstall_sb
    import ldstall_pkg::*;
#(
    parameter int CYC_W = 8,
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ins_vld,
    input  logic [CYC_W-1:0]   ins_base,
    input  logic               src_a_vld,
    input  logic [RIDX_W-1:0]  src_a_idx,
    input  logic               src_b_vld,
    input  logic [RIDX_W-1:0]  src_b_idx,
    input  logic               ld_vld,
    input  logic [RIDX_W-1:0]  ld_idx,
    input  logic               is_cti,
    input  logic               cti_taken,
    input  logic               has_slot,
    input  logic               multi_xfer,
    output logic               res_vld,
    output logic [CYC_W+1:0]   res_cyc,
    output logic [CNT_W-1:0]   cnt_cycles,
    output logic [CNT_W-1:0]   cnt_ld_stall,
    output logic [CNT_W-1:0]   cnt_cti_stall,
    output logic [CNT_W-1:0]   cnt_taken,
    output logic [CNT_W-1:0]   cnt_untaken
);

    localparam int RES_W = CYC_W + 2;
    localparam int NCNT  = 5;

    regref_t   ra, rb, rd;
    logic [1:0] hit_cnt;
    cti_kind_e kind;
    logic [RES_W-1:0] cyc;
    charge_t   chg;

    assign ra   = '{vld: src_a_vld, idx: src_a_idx};
    assign rb   = '{vld: src_b_vld, idx: src_b_idx};
    assign rd   = '{vld: ld_vld,    idx: ld_idx};
    assign kind = classify(is_cti, cti_taken, has_slot);

    ldstall_board u_board (
        .clk     (clk),
        .rst     (rst),
        .adv     (ins_vld),
        .blk     (multi_xfer),
        .src_a   (ra),
        .src_b   (rb),
        .dest    (rd),
        .hit_cnt (hit_cnt)
    );

    ldstall_calc #(.CYC_W(CYC_W)) u_calc (
        .base (ins_base),
        .hits (hit_cnt),
        .kind (kind),
        .blk  (multi_xfer),
        .cyc  (cyc),
        .chg  (chg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld <= 1'b0;
            res_cyc <= '0;
        end else begin
            res_vld <= ins_vld;
            if (ins_vld) res_cyc <= cyc;
        end
    end

    // counter order: cycles, load stalls, transfer bubbles, taken, untaken
    logic [RES_W-1:0] inc_v [NCNT];
    logic [CNT_W-1:0] cnt_v [NCNT];

    always_comb begin
        inc_v[0] = cyc;
        inc_v[1] = RES_W'(chg.ld);
        inc_v[2] = RES_W'(chg.bubble);
        inc_v[3] = RES_W'(chg.taken);
        inc_v[4] = RES_W'(chg.untaken);
    end

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        ldstall_satcnt #(.CNT_W(CNT_W), .INC_W(RES_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .en  (ins_vld),
            .inc (inc_v[g]),
            .cnt (cnt_v[g])
        );
    end

    assign cnt_cycles    = cnt_v[0];
    assign cnt_ld_stall  = cnt_v[1];
    assign cnt_cti_stall = cnt_v[2];
    assign cnt_taken     = cnt_v[3];
    assign cnt_untaken   = cnt_v[4];

endmodule

// File: rtl/ldstall_sb_chk.sv
module ldstall_sb_chk #(
    parameter int CYC_W = 8,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             ins_vld,
    input logic [CYC_W-1:0] ins_base,
    input logic             src_a_vld,
    input logic             src_b_vld,
    input logic             is_cti,
    input logic             cti_taken,
    input logic             has_slot,
    input logic             multi_xfer,
    input logic             res_vld,
    input logic [CYC_W+1:0] res_cyc,
    input logic [CNT_W-1:0] cnt_cycles,
    input logic [CNT_W-1:0] cnt_ld_stall,
    input logic [CNT_W-1:0] cnt_cti_stall,
    input logic [CNT_W-1:0] cnt_taken,
    input logic [CNT_W-1:0] cnt_untaken
);

    localparam int RES_W = CYC_W + 2;

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !ins_vld |=> !res_vld && $stable(cnt_cycles) && $stable(cnt_ld_stall)
                     && $stable(cnt_cti_stall) && $stable(cnt_taken) && $stable(cnt_untaken));

    a_r8_result_bounds: assert property (@(posedge clk) disable iff (rst)
        ins_vld |=> res_vld && (res_cyc >= {2'b00, $past(ins_base)})
                    && (res_cyc <= {2'b00, $past(ins_base)} + RES_W'(3)));

    a_r4_no_source_no_stall: assert property (@(posedge clk) disable iff (rst)
        ins_vld && !src_a_vld && !src_b_vld |=> $stable(cnt_ld_stall));

    a_r9_multi_base_only: assert property (@(posedge clk) disable iff (rst)
        ins_vld && multi_xfer |=> res_cyc == {2'b00, $past(ins_base)} && $stable(cnt_ld_stall)
                                  && $stable(cnt_taken) && $stable(cnt_untaken));

    a_r6_slot_no_bubble: assert property (@(posedge clk) disable iff (rst)
        ins_vld && !multi_xfer && is_cti && cti_taken && has_slot |=> $stable(cnt_cti_stall));

    a_r7_untaken_moves: assert property (@(posedge clk) disable iff (rst)
        ins_vld && !multi_xfer && is_cti && !cti_taken |=>
            (cnt_untaken != $past(cnt_untaken)) || (&cnt_untaken));

    a_r10_never_wraps: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> cnt_cycles >= $past(cnt_cycles) && cnt_ld_stall >= $past(cnt_ld_stall));

endmodule

bind ldstall_sb ldstall_sb_chk #(.CYC_W(CYC_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ins_vld       (ins_vld),
    .ins_base      (ins_base),
    .src_a_vld     (src_a_vld),
    .src_b_vld     (src_b_vld),
    .is_cti        (is_cti),
    .cti_taken     (cti_taken),
    .has_slot      (has_slot),
    .multi_xfer    (multi_xfer),
    .res_vld       (res_vld),
    .res_cyc       (res_cyc),
    .cnt_cycles    (cnt_cycles),
    .cnt_ld_stall  (cnt_ld_stall),
    .cnt_cti_stall (cnt_cti_stall),
    .cnt_taken     (cnt_taken),
    .cnt_untaken   (cnt_untaken)
);

// File: tb/ldstall_sb_tb.sv
`timescale 1ns/1ps
module ldstall_sb_tb;

    localparam int CYC_W = 8;
    localparam int CNT_W = 12;
    localparam int RES_W = CYC_W + 2;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ins_vld = 1'b0;
    logic [CYC_W-1:0] ins_base = '0;
    logic src_a_vld = 1'b0, src_b_vld = 1'b0, ld_vld = 1'b0;
    logic [3:0] src_a_idx = '0, src_b_idx = '0, ld_idx = '0;
    logic is_cti = 1'b0, cti_taken = 1'b0, has_slot = 1'b0, multi_xfer = 1'b0;
    logic res_vld;
    logic [RES_W-1:0] res_cyc;
    logic [CNT_W-1:0] cnt_cycles, cnt_ld_stall, cnt_cti_stall, cnt_taken, cnt_untaken;

    always #4 clk = ~clk;

    ldstall_sb #(.CYC_W(CYC_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .ins_vld(ins_vld), .ins_base(ins_base),
        .src_a_vld(src_a_vld), .src_a_idx(src_a_idx),
        .src_b_vld(src_b_vld), .src_b_idx(src_b_idx),
        .ld_vld(ld_vld), .ld_idx(ld_idx),
        .is_cti(is_cti), .cti_taken(cti_taken), .has_slot(has_slot),
        .multi_xfer(multi_xfer),
        .res_vld(res_vld), .res_cyc(res_cyc),
        .cnt_cycles(cnt_cycles), .cnt_ld_stall(cnt_ld_stall),
        .cnt_cti_stall(cnt_cti_stall), .cnt_taken(cnt_taken), .cnt_untaken(cnt_untaken)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    bit [15:0] m_marks = '0;
    int m_tot = 0, m_ld = 0, m_bub = 0, m_tk = 0, m_ut = 0;

    function automatic int sat(int v, int inc);
        return (v + inc > CMAX) ? CMAX : v + inc;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_counters(string req);
        chk({req, " cnt_cycles"},    cnt_cycles,    m_tot);
        chk({req, " cnt_ld_stall"},  cnt_ld_stall,  m_ld);
        chk({req, " cnt_cti_stall"}, cnt_cti_stall, m_bub);
        chk({req, " cnt_taken"},     cnt_taken,     m_tk);
        chk({req, " cnt_untaken"},   cnt_untaken,   m_ut);
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic issue(string req, int base, bit av, int ai, bit bv, int bi,
                         bit lv, int li, bit c, bit t, bit s, bit m);
        int hits, bub, cyc;
        ins_vld = 1'b1; ins_base = CYC_W'(base);
        src_a_vld = av; src_a_idx = 4'(ai);
        src_b_vld = bv; src_b_idx = 4'(bi);
        ld_vld = lv; ld_idx = 4'(li);
        is_cti = c; cti_taken = t; has_slot = s; multi_xfer = m;
        hits = 0; bub = 0;
        if (!m) begin
            if (av && m_marks[ai]) hits++;
            if (bv && m_marks[bi]) hits++;
            if (c && t && !s) bub = 1;
        end
        cyc = base + hits + bub;
        m_tot = sat(m_tot, cyc);
        m_ld  = sat(m_ld, hits);
        m_bub = sat(m_bub, bub);
        m_tk  = sat(m_tk, (!m && c && t) ? 1 : 0);
        m_ut  = sat(m_ut, (!m && c && !t) ? 1 : 0);
        m_marks = (lv && !m) ? (16'h1 << li) : 16'h0;
        @(negedge clk);
        ins_vld = 1'b0;
        chk({req, " res_vld"}, res_vld, 1);
        chk({req, " res_cyc"}, res_cyc, cyc);
        chk_counters(req);
    endtask

    task automatic idle(string req);
        ins_vld = 1'b0;
        ld_vld = 1'b1; ld_idx = 4'd7; src_a_vld = 1'b1; src_a_idx = 4'd7;
        is_cti = 1'b1; cti_taken = 1'b1;
        @(negedge clk);
        chk({req, " res_vld idle"}, res_vld, 0);
        chk_counters(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 res_vld", res_vld, 0);
        chk_counters("R1");
        rst = 1'b0;
        @(negedge clk);
        chk("R1 res_vld after release", res_vld, 0);
        // R1: no marks after reset -> consumer sees no stall
        issue("R1 clean marks", 2, 1, 0, 1, 15, 0, 0, 0, 0, 0, 0);

        // R3/R4/R2: sweep every load destination against every source index
        for (int d = 0; d < 16; d++) begin
            for (int s = 0; s < 16; s++) begin
                issue("R2 load", 1, 0, 0, 0, 0, 1, d, 0, 0, 0, 0);
                issue("R3 R4 consumer", 1, 1, s, (s % 2 == 0), (s + d) % 16, 0, 0, 0, 0, 0, 0);
            end
        end

        // R3: two sources hitting the same mark
        issue("R3 load r9", 3, 0, 0, 0, 0, 1, 9, 0, 0, 0, 0);
        issue("R3 double hit", 3, 1, 9, 1, 9, 0, 0, 0, 0, 0, 0);
        // R4: absent sources with marked index
        issue("R4 load r5", 3, 0, 0, 0, 0, 1, 5, 0, 0, 0, 0);
        issue("R4 absent sources", 3, 0, 5, 0, 5, 0, 0, 0, 0, 0, 0);

        // R2: own destination is not a hazard, but the next one is
        issue("R2 self load", 2, 1, 3, 0, 0, 1, 3, 0, 0, 0, 0);
        issue("R2 chained load", 2, 1, 3, 0, 0, 1, 3, 0, 0, 0, 0);

        // R5: intervening non-load clears marks
        issue("R5 load r2", 1, 0, 0, 0, 0, 1, 2, 0, 0, 0, 0);
        issue("R5 filler", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        issue("R5 late consumer", 1, 1, 2, 1, 2, 0, 0, 0, 0, 0, 0);

        // R11: idle cycles between load and consumer leave mark intact
        issue("R11 load r6", 1, 0, 0, 0, 0, 1, 6, 0, 0, 0, 0);
        idle("R11");
        idle("R11");
        issue("R11 consumer after idle", 1, 1, 6, 0, 0, 0, 0, 0, 0, 0, 0);

        // R6/R7: all transfer flag combinations, with and without a hazard
        for (int k = 0; k < 16; k++) begin
            issue("R6 R7 load r1", 1, 0, 0, 0, 0, (k >= 8), 1, 0, 0, 0, 0);
            issue("R6 R7 transfer", k % 8 + 1, 1, 1, 0, 0, 0, 0, k[2], k[1], k[0], 0);
        end

        // R9: multi-register transfer
        issue("R9 load r4", 2, 0, 0, 0, 0, 1, 4, 0, 0, 0, 0);
        issue("R9 multi on marked reg", 5, 1, 4, 1, 4, 1, 8, 1, 1, 0, 1);
        issue("R9 consumer after multi", 2, 1, 8, 1, 4, 0, 0, 0, 0, 0, 0);

        // R10: saturate load-stall, bubble, taken and total counters
        for (int i = 0; i < 4200; i++)
            issue("R10 taken chain", 3, 1, 1, 1, 1, 1, 1, 1, 1, 0, 0);
        // R10: saturate untaken counter
        for (int i = 0; i < 4200; i++)
            issue("R10 untaken chain", 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        chk("R10 ld_stall saturated", cnt_ld_stall, CMAX);
        chk("R10 untaken saturated", cnt_untaken, CMAX);
        idle("R10 R11");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule